// File: doc/BRIEF.md
# Sync-Tagged ADC Channel Demultiplexer

This block sits beside a parallel-output multichannel analog-to-digital converter. It reads one result word for each falling edge of the converter's free-running conversion clock. It works out which analog channel each word belongs to, and it hands the word on as a tagged sample: data, channel index and a one-cycle valid strobe.

The channel number is not just counted from reset. In multichannel operation the converter pulls an active-low frame marker low only while the first channel's word is on the bus, and the block re-anchors its channel counter on that marker in every frame. A frame marker that comes too early, or one that is missing where the first channel is expected, raises a sticky alignment error. The block then searches for the marker again. With one channel configured, the converter does not drive the marker, so every word is tagged as channel 0 at once.

The conversion clock is taken as a slow square wave that is synchronous to the system clock and is sampled by it. The read strobe toward the converter consists of two chip-select lines and a read-enable line, all active low. The converter counts a read only while all three are low.

Top module: `adc_chan_demux`

## Requirements
- R1: For each high-to-low change of the sampled conversion clock, `chip_sel_a_n`, `chip_sel_b_n` and `read_en_n` all go low together for exactly one clock cycle, starting at the first rising edge that samples the clock low. At no other time are they low.
- R2: The bus word and frame-marker level present during the read cycle are captured at the rising edge that ends the read cycle. An accepted word appears on `smp_data` with `smp_valid` high two cycles after the read strobe went low.
- R3: `smp_valid` is high for exactly one cycle per accepted word and is never high in two consecutive cycles.
- R4: With an effective channel count of 1, every word is accepted and tagged channel 0, the frame marker is ignored, and `align_err` stays 0.
- R5: After reset with an effective channel count of 2 or more, words are discarded until the first word with `frame_sync_n` = 0. That word is accepted as channel 0.
- R6: Once locked, the words after a channel-0 word are tagged 1, 2, ... up to count-1 in ascending order, and the next word is again expected as channel 0.
- R7: When locked, a word with `frame_sync_n` = 0 in a position where channel 1 or higher is expected sets `align_err`. That word is discarded and the block hunts for the next frame marker.
- R8: When locked, a word with `frame_sync_n` = 1 in the position where channel 0 is expected sets `align_err`. That word is discarded and the block hunts.
- R9: `align_err` stays set until reset. Reset (`rst` = 1, synchronous) clears `align_err` and `smp_valid` and drives all three strobe lines high.
- R10: `chan_count` is binary. A value of 0 behaves as 1, and a value above MAX_CH (4 by default) behaves as MAX_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_clk | input | 1 | Conversion clock, synchronous to clk |
| adc_bus | input | DATA_W (10) | Converter result bus |
| frame_sync_n | input | 1 | Active-low first-channel marker |
| chan_count | input | $clog2(MAX_CH+1) (3) | Configured number of active channels |
| chip_sel_a_n | output | 1 | Chip-select A, active low |
| chip_sel_b_n | output | 1 | Chip-select B, active low |
| read_en_n | output | 1 | Read enable, active low |
| smp_data | output | DATA_W (10) | Tagged sample data |
| smp_chan | output | $clog2(MAX_CH) (2) | Channel index of the sample |
| smp_valid | output | 1 | One-cycle strobe per accepted sample |
| align_err | output | 1 | Sticky frame-alignment error |

## Verification
The in-line properties check the following on every cycle: the read strobe has a single-cycle shape and follows a sampled fall; the two-cycle distance from read to sample; `smp_valid` lasts one cycle; channel indexes stay below the effective count; single-channel tagging; and both misalignment cases set an error that never clears. Only the bench's scenarios can show other behaviour. That includes the actual data-to-channel mapping across whole frames, the discard of words before the first marker and after an error, and re-anchoring on a later marker. It also includes the clamping of out-of-range counts and the one-read-per-word total over a run. The bench sweeps every `chan_count` value from 0 to 7 and compares the results with an arithmetic tag model.

// File: rtl/adcdmx_pkg.sv
package adcdmx_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } align_state_e;

    // Effective channel count: below 1 becomes 1, above max becomes max.
    function automatic int clamp_count(int raw, int max_ch);
        if (raw < 1) begin
            return 1;
        end
        if (raw > max_ch) begin
            return max_ch;
        end
        return raw;
    endfunction

    // Ascending channel index with wrap at the effective count.
    function automatic int next_index(int cur, int n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/adcdmx_edge.sv
module adcdmx_edge (
    input  logic clk,
    input  logic rst,
    input  logic conv_clk,
    output logic rd_act
);
    logic conv_q;
    logic fall;

    assign fall = conv_q & ~conv_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_q <= 1'b0;
            rd_act <= 1'b0;
        end else begin
            conv_q <= conv_clk;
            rd_act <= fall;
        end
    end

    // R1
    read_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        rd_act |=> !rd_act);

    // R1
    read_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        rd_act |-> !conv_q);

endmodule

// File: rtl/adcdmx_capture.sv
module adcdmx_capture #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              sync_n_in,
    output logic              cap_vld,
    output logic [DATA_W-1:0] cap_data,
    output logic              cap_sync_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_vld    <= 1'b0;
            cap_data   <= '0;
            cap_sync_n <= 1'b1;
        end else begin
            cap_vld <= take;
            if (take) begin
                cap_data   <= bus_in;
                cap_sync_n <= sync_n_in;
            end
        end
    end

endmodule

// File: rtl/adcdmx_tagger.sv
module adcdmx_tagger
    import adcdmx_pkg::*;
#(
    parameter  int DATA_W = 10,
    parameter  int MAX_CH = 4,
    localparam int CHW    = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
    localparam int CFG_W  = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_count,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sync_n,
    output logic [DATA_W-1:0] out_data,
    output logic [CHW-1:0]    out_chan,
    output logic              out_valid,
    output logic              align_err
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHW-1:0]    chan;
        logic              valid;
    } tag_word_t;

    logic [CFG_W-1:0] n_eff;
    logic             single;
    align_state_e     state, nxt_state;
    logic [CHW-1:0]   cnt, nxt_cnt;
    logic             accept, err_set;
    logic [CHW-1:0]   tag;
    tag_word_t        word_q;

    always_comb begin
        n_eff  = CFG_W'(clamp_count(int'(cfg_count), MAX_CH));
        single = (n_eff == CFG_W'(1));
    end

    always_comb begin
        accept    = 1'b0;
        err_set   = 1'b0;
        tag       = '0;
        nxt_state = state;
        nxt_cnt   = cnt;
        if (in_vld) begin
            if (single) begin
                accept  = 1'b1;
                nxt_cnt = '0;
            end else if (state == ST_HUNT) begin
                if (!in_sync_n) begin
                    accept    = 1'b1;
                    nxt_state = ST_LOCK;
                    nxt_cnt   = CHW'(next_index(0, int'(n_eff)));
                end
            end else if ((cnt == '0) == in_sync_n) begin
                // marker missing at channel 0, or present elsewhere
                err_set   = 1'b1;
                nxt_state = ST_HUNT;
                nxt_cnt   = '0;
            end else begin
                accept  = 1'b1;
                tag     = cnt;
                nxt_cnt = CHW'(next_index(int'(cnt), int'(n_eff)));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            word_q    <= '0;
            align_err <= 1'b0;
        end else begin
            state        <= nxt_state;
            cnt          <= nxt_cnt;
            word_q.valid <= accept;
            if (accept) begin
                word_q.data <= in_data;
                word_q.chan <= tag;
            end
            if (err_set) begin
                align_err <= 1'b1;
            end
        end
    end

    assign out_data  = word_q.data;
    assign out_chan  = word_q.chan;
    assign out_valid = word_q.valid;

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R4
    single_chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && single) |-> (out_chan == '0));

    // R5
    hunt_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !single && state == ST_HUNT && in_sync_n) |=> !out_valid);

    // R6
    chan_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (CFG_W'(out_chan) < n_eff));

    // R7
    early_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !single && state == ST_LOCK && cnt != '0 && !in_sync_n)
            |=> (align_err && !out_valid));

    // R8
    missing_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !single && state == ST_LOCK && cnt == '0 && in_sync_n)
            |=> (align_err && !out_valid));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        align_err |=> align_err);

endmodule

// File: rtl/adc_chan_demux.sv
module adc_chan_demux #(
    parameter  int DATA_W = 10,
    parameter  int MAX_CH = 4,
    localparam int CHW    = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
    localparam int CFG_W  = $clog2(MAX_CH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_clk,
    input  logic [DATA_W-1:0] adc_bus,
    input  logic              frame_sync_n,
    input  logic [CFG_W-1:0]  chan_count,
    output logic              chip_sel_a_n,
    output logic              chip_sel_b_n,
    output logic              read_en_n,
    output logic [DATA_W-1:0] smp_data,
    output logic [CHW-1:0]    smp_chan,
    output logic              smp_valid,
    output logic              align_err
);
    logic              rd_act;
    logic              cap_vld;
    logic [DATA_W-1:0] cap_data;
    logic              cap_sync_n;

    adcdmx_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .conv_clk (conv_clk),
        .rd_act   (rd_act)
    );

    assign chip_sel_a_n = ~rd_act;
    assign chip_sel_b_n = ~rd_act;
    assign read_en_n    = ~rd_act;

    adcdmx_capture #(.DATA_W(DATA_W)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .take       (rd_act),
        .bus_in     (adc_bus),
        .sync_n_in  (frame_sync_n),
        .cap_vld    (cap_vld),
        .cap_data   (cap_data),
        .cap_sync_n (cap_sync_n)
    );

    adcdmx_tagger #(.DATA_W(DATA_W), .MAX_CH(MAX_CH)) u_tagger (
        .clk       (clk),
        .rst       (rst),
        .cfg_count (chan_count),
        .in_vld    (cap_vld),
        .in_data   (cap_data),
        .in_sync_n (cap_sync_n),
        .out_data  (smp_data),
        .out_chan  (smp_chan),
        .out_valid (smp_valid),
        .align_err (align_err)
    );

    // R2
    read_to_sample_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> $past(!read_en_n, 2));

endmodule

// File: tb/test_adc_chan_demux.sv
module test_adc_chan_demux;
    localparam int DATA_W = 10;
    localparam int MAX_CH = 4;
    localparam int CHW    = 2;
    localparam int CFG_W  = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              conv_clk = 1'b1;
    logic [DATA_W-1:0] adc_bus = '0;
    logic              frame_sync_n = 1'b1;
    logic [CFG_W-1:0]  chan_count = 3'd1;
    logic              chip_sel_a_n, chip_sel_b_n, read_en_n;
    logic [DATA_W-1:0] smp_data;
    logic [CHW-1:0]    smp_chan;
    logic              smp_valid, align_err;

    always #5 clk = ~clk;

    adc_chan_demux i_adc_chan_demux (
        .clk(clk), .rst(rst), .conv_clk(conv_clk), .adc_bus(adc_bus),
        .frame_sync_n(frame_sync_n), .chan_count(chan_count),
        .chip_sel_a_n(chip_sel_a_n), .chip_sel_b_n(chip_sel_b_n),
        .read_en_n(read_en_n), .smp_data(smp_data), .smp_chan(smp_chan),
        .smp_valid(smp_valid), .align_err(align_err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int word_ctr = 0;
    int words_sent = 0;
    int reads_seen = 0;

    // bench tag model state
    int  m_n = 1;
    bit  m_hunt = 1;
    int  m_cnt = 0;
    bit  m_err = 0;
    logic [DATA_W+CHW-1:0] exp_q[$];

    bit rd_d1 = 0, rd_d2 = 0, prev_valid = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            logic rd_now;
            rd_now = !chip_sel_a_n && !chip_sel_b_n && !read_en_n;
            if (!(chip_sel_a_n == chip_sel_b_n && chip_sel_b_n == read_en_n)) begin
                chk(0, "R1 strobe lines split", int'(chip_sel_a_n), int'(read_en_n));
            end
            if (rd_now) reads_seen++;
            if (smp_valid) begin
                chk(rd_d2, "R2 read two cycles earlier", int'(rd_d2), 1);
                chk(!prev_valid, "R3 valid pulse width", int'(prev_valid), 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R5 unexpected sample", int'({smp_data, smp_chan}), -1);
                end else begin
                    logic [DATA_W+CHW-1:0] e;
                    e = exp_q.pop_front();
                    chk({smp_data, smp_chan} == e, "R6 data/channel tag",
                        int'({smp_data, smp_chan}), int'(e));
                end
            end
            rd_d2 = rd_d1;
            rd_d1 = rd_now;
            prev_valid = smp_valid;
        end else begin
            rd_d1 = 0; rd_d2 = 0; prev_valid = 0;
        end
    end

    function automatic int clamp_n(int raw);
        return (raw < 1) ? 1 : ((raw > MAX_CH) ? MAX_CH : raw);
    endfunction

    function automatic void model_word(logic [DATA_W-1:0] d, bit s);
        if (m_n == 1) begin
            exp_q.push_back({d, 2'd0});
        end else if (m_hunt) begin
            if (!s) begin
                exp_q.push_back({d, 2'd0});
                m_cnt = 1;
                m_hunt = 0;
            end
        end else if ((m_cnt == 0) == s) begin
            m_err = 1;
            m_hunt = 1;
            m_cnt = 0;
        end else begin
            exp_q.push_back({d, CHW'(m_cnt)});
            m_cnt = (m_cnt + 1 >= m_n) ? 0 : m_cnt + 1;
        end
    endfunction

    task automatic send_word(input bit s);
        logic [DATA_W-1:0] d;
        d = DATA_W'((word_ctr * 149 + 23) % 1024);
        word_ctr++;
        conv_clk = 1'b1;
        repeat (3) @(negedge clk);
        adc_bus = d;
        frame_sync_n = s;
        conv_clk = 1'b0;
        words_sent++;
        model_word(d, s);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frames(input int frames);
        for (int f = 0; f < frames; f++) begin
            for (int c = 0; c < m_n; c++) begin
                send_word(c != 0);
            end
        end
    endtask

    task automatic do_reset(input int raw);
        @(negedge clk);
        rst = 1'b1;
        conv_clk = 1'b1;
        frame_sync_n = 1'b1;
        chan_count = CFG_W'(raw);
        repeat (3) @(negedge clk);
        chk(chip_sel_a_n && chip_sel_b_n && read_en_n, "R9 strobes high in reset",
            int'({chip_sel_a_n, chip_sel_b_n, read_en_n}), 7);
        chk(!smp_valid, "R9 valid low in reset", int'(smp_valid), 0);
        chk(!align_err, "R9 error cleared by reset", int'(align_err), 0);
        rst = 1'b0;
        exp_q.delete();
        m_n = clamp_n(raw);
        m_hunt = 1; m_cnt = 0; m_err = 0;
        words_sent = 0; reads_seen = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_scenario(input string tag);
        conv_clk = 1'b1;
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " all expected samples seen"}, exp_q.size(), 0);
        chk(reads_seen == words_sent, "R1 one read per falling edge", reads_seen, words_sent);
        chk(align_err == m_err, {tag, " align_err level"}, int'(align_err), int'(m_err));
    endtask

    initial begin
        // sweep every configuration value, including out-of-range ones (R10)
        for (int raw = 0; raw < 8; raw++) begin
            do_reset(raw);
            send_word(1);
            send_word(1);
            if (m_n == 1) begin
                for (int k = 0; k < 6; k++) send_word(k[0]);   // R4 marker ignored
            end
            send_frames(3);
            finish_scenario((raw == 0 || raw > MAX_CH) ? "R10 clamped count" :
                            (m_n == 1) ? "R4 single channel" : "R5 hunt then lock");
        end

        // R7: marker low where channel 1 is expected
        do_reset(3);
        send_frames(1);
        send_word(0);
        send_word(0);
        send_word(1);
        send_word(1);
        send_frames(2);
        finish_scenario("R7 early marker");
        chk(align_err, "R9 error still set after relock", int'(align_err), 1);

        // R8: marker missing where channel 0 is expected
        do_reset(4);
        send_frames(1);
        send_word(1);
        send_word(1);
        send_word(1);
        send_word(1);
        send_frames(2);
        finish_scenario("R8 missing marker");

        // R9: reset clears the sticky error
        do_reset(2);
        send_frames(2);
        finish_scenario("R9 clean run after reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule